// File: doc/BRIEF.md
# Masked Three-Input Bitwise Vector Unit

This unit evaluates any three-input bitwise function over three wide source vectors in a single step. The function is given as an 8-bit truth table. For every bit position, the three source bits at that position form an index into the table, and the table bit at that index becomes the result bit. The raw result then passes through a write mask before it is captured in the output register.

The write mask is taken from a small bank of mask registers. A 3-bit selector picks the mask register to use. Selector value 0 is reserved to mean "every lane enabled". The element-size field controls only how mask bits map onto lanes; the bitwise function itself is the same for every element size. A zeroing/merging control sets what a disabled lane receives. In zeroing mode it receives zero. In merging mode it keeps the old destination value that the caller supplies.

The mask bank has its own write port and an independent combinational read port. Every register, including register 0, can be written and read back through these ports.

Top module: `ternlog_mask_unit`

## Requirements
- R1: Result bit j equals func_imm[{src_a[j], src_b[j], src_c[j]}], where src_a is the most significant bit of the 3-bit index and src_c the least, for every bit of an enabled lane.
- R2: When mask_sel is 0, every lane is enabled, whatever mask register 0 holds.
- R3: When mask_sel is 1 to 7, lane i is enabled exactly when bit i of the selected mask register is 1.
- R4: In zeroing mode (zero_mode = 1), every bit of a disabled lane is 0 in the result.
- R5: In merging mode (zero_mode = 0), every bit of a disabled lane equals the matching bit of dst_old.
- R6: elem_sel encodes the lane width as 0 = 8-bit (64 lanes), 1 = 16-bit (32 lanes), 2 = 32-bit (16 lanes), 3 = 64-bit (8 lanes). Lane i covers bits i*width to i*width+width-1.
- R7: Mask bits at positions equal to or above the lane count of the selected width have no effect on the result.
- R8: When kwr_en is 1 at a clock edge, mask register kwr_idx takes kwr_data. krd_data always shows mask register krd_idx. This includes register 0.
- R9: result and out_valid update one clock edge after in_valid is sampled high. out_valid is 0 in every other cycle, and result holds its value while in_valid is low.
- R10: After reset, out_valid is 0, result is 0 and every mask register is 0.
- R11: A mask register write and an operation in the same cycle leave the operation using the mask value from before the write.

Ports table:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operation strobe |
| src_a | input | 512 | First source (index MSB) |
| src_b | input | 512 | Second source |
| src_c | input | 512 | Third source (index LSB) |
| dst_old | input | 512 | Prior destination value for merging |
| func_imm | input | 8 | Truth table of the bitwise function |
| elem_sel | input | 2 | Lane width code |
| mask_sel | input | 3 | Mask register selector, 0 = unmasked |
| zero_mode | input | 1 | 1 = zero disabled lanes, 0 = merge |
| kwr_en | input | 1 | Mask bank write enable |
| kwr_idx | input | 3 | Mask bank write index |
| kwr_data | input | 64 | Mask bank write data |
| krd_idx | input | 3 | Mask bank read index |
| krd_data | output | 64 | Mask bank read data |
| out_valid | output | 1 | Result valid |
| result | output | 512 | Registered masked result |

## Verification
Some properties are checked on every cycle by assertions:
- the one-cycle latency of out_valid and the hold of result between operations;
- that an unmasked pass-through table copies the first source;
- that an all-zero table under zeroing gives zero;
- that an all-zero table under merging never sets a bit absent from dst_old;
- that a mask write is visible on the read port.

Other behaviour depends on the contents of the mask bank, so only the bench scenarios can show it. This covers the per-lane mapping at each element width, the ignored upper mask bits, the mixing of enabled and disabled lanes, and the ordering of a write that coincides with an operation.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
   // Lane width code; the value is log2 of the lane width in bytes.
   typedef enum logic [1:0] {
      ESZ_B8  = 2'd0,
      ESZ_B16 = 2'd1,
      ESZ_B32 = 2'd2,
      ESZ_B64 = 2'd3
   } esize_e;

   localparam int unsigned ESZ_COUNT = 4;
   localparam int unsigned TT_BITS   = 8;
endpackage

// File: rtl/tlu_bitfunc.sv
module tlu_bitfunc #(
   parameter int unsigned VW = 512
) (
   input  logic [VW-1:0]              a,
   input  logic [VW-1:0]              b,
   input  logic [VW-1:0]              c,
   input  logic [tlu_pkg::TT_BITS-1:0] tt,
   output logic [VW-1:0]              y
);
   // One 8:1 selection per bit; the three source bits form the index.
   for (genvar i = 0; i < VW; i++) begin : g_bit
      assign y[i] = tt[{a[i], b[i], c[i]}];
   end
endmodule

// File: rtl/tlu_mask_bank.sv
module tlu_mask_bank #(
   parameter int unsigned MW = 64,
   parameter int unsigned NK = 8,
   localparam int unsigned SW = $clog2(NK)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [SW-1:0] wr_idx,
   input  logic [MW-1:0] wr_data,
   input  logic [SW-1:0] rd_idx,
   output logic [MW-1:0] rd_data,
   input  logic [SW-1:0] sel_idx,
   output logic [MW-1:0] eff_mask
);
   logic [MW-1:0] kreg [NK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(NK); i++) kreg[i] <= '0;
      end else if (wr_en) begin
         kreg[wr_idx] <= wr_data;
      end
   end

   assign rd_data = kreg[rd_idx];

   // Selector 0 is reserved for "no masking": register 0 is never applied.
   always_comb begin
      if (sel_idx == '0) eff_mask = '1;
      else               eff_mask = kreg[sel_idx];
   end
endmodule

// File: rtl/tlu_lane_expand.sv
module tlu_lane_expand #(
   parameter int unsigned VW = 512,
   localparam int unsigned NB = VW / 8,
   localparam int unsigned MW = NB
) (
   input  logic [MW-1:0]       mask,
   input  tlu_pkg::esize_e     esz,
   output logic [VW-1:0]       bit_en
);
   logic [NB-1:0] byte_en;

   // One byte-enable map per lane width; byte b belongs to lane b >> s.
   for (genvar s = 0; s < int'(tlu_pkg::ESZ_COUNT); s++) begin : g_sz
      logic [NB-1:0] be;
      for (genvar b = 0; b < int'(NB); b++) begin : g_byte
         assign be[b] = mask[b >> s];
      end
   end

   always_comb begin
      unique case (esz)
         tlu_pkg::ESZ_B8:  byte_en = g_sz[0].be;
         tlu_pkg::ESZ_B16: byte_en = g_sz[1].be;
         tlu_pkg::ESZ_B32: byte_en = g_sz[2].be;
         default:          byte_en = g_sz[3].be;
      endcase
   end

   for (genvar b = 0; b < int'(NB); b++) begin : g_bits
      assign bit_en[b*8 +: 8] = {8{byte_en[b]}};
   end
endmodule

// File: rtl/ternlog_mask_unit.sv
module ternlog_mask_unit #(
   parameter int unsigned VEC_W    = 512,
   parameter int unsigned NUM_MASK = 8,
   localparam int unsigned MASK_W  = VEC_W / 8,
   localparam int unsigned SEL_W   = $clog2(NUM_MASK)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [VEC_W-1:0]            src_a,
   input  logic [VEC_W-1:0]            src_b,
   input  logic [VEC_W-1:0]            src_c,
   input  logic [VEC_W-1:0]            dst_old,
   input  logic [tlu_pkg::TT_BITS-1:0] func_imm,
   input  logic [1:0]                  elem_sel,
   input  logic [SEL_W-1:0]            mask_sel,
   input  logic                        zero_mode,
   input  logic                        kwr_en,
   input  logic [SEL_W-1:0]            kwr_idx,
   input  logic [MASK_W-1:0]           kwr_data,
   input  logic [SEL_W-1:0]            krd_idx,
   output logic [MASK_W-1:0]           krd_data,
   output logic                        out_valid,
   output logic [VEC_W-1:0]            result
);
   // Elaboration-time parameter checks
   if (VEC_W % 64 != 0) begin : g_bad_vw
      $error("VEC_W must be a multiple of 64");
   end
   if (NUM_MASK < 2 || (NUM_MASK & (NUM_MASK - 1)) != 0) begin : g_bad_nk
      $error("NUM_MASK must be a power of two, at least 2");
   end

   logic [VEC_W-1:0]  fn_out;
   logic [MASK_W-1:0] eff_mask;
   logic [VEC_W-1:0]  bit_en;
   logic [VEC_W-1:0]  keep_old;
   logic [VEC_W-1:0]  next_res;

   tlu_bitfunc #(.VW(VEC_W)) i_func (
      .a  (src_a),
      .b  (src_b),
      .c  (src_c),
      .tt (func_imm),
      .y  (fn_out)
   );

   tlu_mask_bank #(.MW(MASK_W), .NK(NUM_MASK)) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (kwr_en),
      .wr_idx   (kwr_idx),
      .wr_data  (kwr_data),
      .rd_idx   (krd_idx),
      .rd_data  (krd_data),
      .sel_idx  (mask_sel),
      .eff_mask (eff_mask)
   );

   tlu_lane_expand #(.VW(VEC_W)) i_lanes (
      .mask   (eff_mask),
      .esz    (tlu_pkg::esize_e'(elem_sel)),
      .bit_en (bit_en)
   );

   assign keep_old = dst_old & ~bit_en & {VEC_W{~zero_mode}};
   assign next_res = (fn_out & bit_en) | keep_old;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) result <= next_res;
      end
   end
endmodule

// File: rtl/tlu_checker.sv
module tlu_checker #(
   parameter int unsigned VEC_W  = 512,
   parameter int unsigned MASK_W = 64,
   parameter int unsigned SEL_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [VEC_W-1:0]  src_a,
   input logic [VEC_W-1:0]  dst_old,
   input logic [7:0]        func_imm,
   input logic [SEL_W-1:0]  mask_sel,
   input logic              zero_mode,
   input logic              kwr_en,
   input logic [SEL_W-1:0]  kwr_idx,
   input logic [MASK_W-1:0] kwr_data,
   input logic [SEL_W-1:0]  krd_idx,
   input logic [MASK_W-1:0] krd_data,
   input logic              out_valid,
   input logic [VEC_W-1:0]  result
);
   assert_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(result));

   assert_unmasked_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && mask_sel == '0 && func_imm == 8'hF0) |=> result == $past(src_a));

   assert_zeroing_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && zero_mode && func_imm == 8'h00) |=> result == '0);

   assert_merge_subset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !zero_mode && func_imm == 8'h00) |=> (result & ~$past(dst_old)) == '0);

   assert_kwrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
      kwr_en |=> (krd_idx != $past(kwr_idx)) || (krd_data == $past(kwr_data)));
endmodule

bind ternlog_mask_unit tlu_checker #(
   .VEC_W (VEC_W),
   .MASK_W(MASK_W),
   .SEL_W (SEL_W)
) i_tlu_checker (
   .clk      (clk),
   .rst_n    (rst_n),
   .in_valid (in_valid),
   .src_a    (src_a),
   .dst_old  (dst_old),
   .func_imm (func_imm),
   .mask_sel (mask_sel),
   .zero_mode(zero_mode),
   .kwr_en   (kwr_en),
   .kwr_idx  (kwr_idx),
   .kwr_data (kwr_data),
   .krd_idx  (krd_idx),
   .krd_data (krd_data),
   .out_valid(out_valid),
   .result   (result)
);

// File: tb/test_ternlog_mask_unit.sv
module test_ternlog_mask_unit;
   localparam int VW = 512;
   localparam int MW = 64;

   typedef struct {
      logic [VW-1:0] exp;
      string         tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [VW-1:0] src_a = '0, src_b = '0, src_c = '0, dst_old = '0;
   logic [7:0]    func_imm = '0;
   logic [1:0]    elem_sel = '0;
   logic [2:0]    mask_sel = '0;
   logic          zero_mode = 1'b0;
   logic          kwr_en = 1'b0;
   logic [2:0]    kwr_idx = '0;
   logic [MW-1:0] kwr_data = '0;
   logic [2:0]    krd_idx = '0;
   logic [MW-1:0] krd_data;
   logic          out_valid;
   logic [VW-1:0] result;

   int            n_checks = 0;
   int            n_fail = 0;
   item_t         sb[$];
   logic [MW-1:0] kmodel [8];
   logic [VW-1:0] last_exp = '0;

   always #10 clk = ~clk;

   ternlog_mask_unit i_ternlog_mask_unit (
      .clk, .rst_n, .in_valid, .src_a, .src_b, .src_c, .dst_old, .func_imm,
      .elem_sel, .mask_sel, .zero_mode, .kwr_en, .kwr_idx, .kwr_data,
      .krd_idx, .krd_data, .out_valid, .result
   );

   task automatic check(string tag, logic [VW-1:0] act, logic [VW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [VW-1:0] rnd_vec();
      logic [VW-1:0] v;
      for (int i = 0; i < VW / 32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic logic [VW-1:0] model(logic [VW-1:0] a, logic [VW-1:0] b,
                                           logic [VW-1:0] c, logic [VW-1:0] d,
                                           logic [7:0] imm, logic [1:0] esz,
                                           logic [2:0] sel, logic zm);
      logic [VW-1:0] r;
      for (int j = 0; j < VW; j++) begin
         int  lane;
         logic en, f;
         lane = (j / 8) >> esz;
         en   = (sel == 3'd0) ? 1'b1 : kmodel[sel][lane];
         f    = imm[{a[j], b[j], c[j]}];
         r[j] = en ? f : (zm ? 1'b0 : d[j]);
      end
      return r;
   endfunction

   // Driver: called just after a falling edge.
   task automatic do_op(string tag, logic [VW-1:0] a, logic [VW-1:0] b,
                        logic [VW-1:0] c, logic [VW-1:0] d, logic [7:0] imm,
                        logic [1:0] esz, logic [2:0] sel, logic zm,
                        logic kw, logic [2:0] kidx, logic [MW-1:0] kdat);
      item_t it;
      src_a = a; src_b = b; src_c = c; dst_old = d; func_imm = imm;
      elem_sel = esz; mask_sel = sel; zero_mode = zm; in_valid = 1'b1;
      it.exp = model(a, b, c, d, imm, esz, sel, zm);
      it.tag = tag;
      last_exp = it.exp;
      sb.push_back(it);
      kwr_en = kw; kwr_idx = kidx; kwr_data = kdat;
      if (kw) kmodel[kidx] = kdat;
      @(negedge clk);
      in_valid = 1'b0;
      kwr_en = 1'b0;
   endtask

   task automatic kwrite(logic [2:0] idx, logic [MW-1:0] dat);
      kwr_en = 1'b1; kwr_idx = idx; kwr_data = dat;
      kmodel[idx] = dat;
      @(negedge clk);
      kwr_en = 1'b0;
   endtask

   // Monitor: pops one expected item per valid output.
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (sb.size() == 0) begin
            n_checks++; n_fail++;
            $display("FAIL R9 actual=unexpected out_valid expected=no output");
         end else begin
            item_t it;
            it = sb.pop_front();
            check(it.tag, result, it.exp);
         end
      end
   end

   initial begin
      #(20 * 150000);
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end

   initial begin
      logic [VW-1:0] a, b, c, d;
      for (int i = 0; i < 8; i++) kmodel[i] = '0;
      repeat (3) @(negedge clk);
      // R10: reset state
      check("R10 out_valid", VW'(out_valid), '0);
      check("R10 result", result, '0);
      krd_idx = 3'd5; #1;
      check("R10 mask bank", VW'(krd_data), '0);
      rst_n = 1'b1;
      @(negedge clk);

      a = rnd_vec(); b = rnd_vec(); c = rnd_vec(); d = rnd_vec();
      // R1: several truth tables, unmasked
      do_op("R1 imm F0", a, b, c, d, 8'hF0, 2'd2, 3'd0, 1'b1, 1'b0, 3'd0, '0);
      do_op("R1 imm CC", a, b, c, d, 8'hCC, 2'd2, 3'd0, 1'b1, 1'b0, 3'd0, '0);
      do_op("R1 imm AA", a, b, c, d, 8'hAA, 2'd3, 3'd0, 1'b0, 1'b0, 3'd0, '0);
      do_op("R1 xor3", a, b, c, d, 8'h96, 2'd0, 3'd0, 1'b0, 1'b0, 3'd0, '0);
      do_op("R1 majority", a, b, c, d, 8'hE8, 2'd1, 3'd0, 1'b1, 1'b0, 3'd0, '0);
      do_op("R1 imm 1D", rnd_vec(), rnd_vec(), rnd_vec(), d, 8'h1D, 2'd2, 3'd0, 1'b0, 1'b0, 3'd0, '0);

      // R2: selector 0 ignores register 0 contents
      kwrite(3'd0, 64'h0);
      do_op("R2 k0 zero", a, b, c, d, 8'h96, 2'd2, 3'd0, 1'b1, 1'b0, 3'd0, '0);
      check("R2 all lanes", last_exp, a ^ b ^ c);

      // R8: register 0 is writable and readable
      kwrite(3'd0, 64'hDEAD_BEEF_0123_4567);
      krd_idx = 3'd0; #1;
      check("R8 k0 readback", VW'(krd_data), VW'(64'hDEAD_BEEF_0123_4567));
      kwrite(3'd6, 64'h0F0F_F0F0_1234_ABCD);
      krd_idx = 3'd6; #1;
      check("R8 k6 readback", VW'(krd_data), VW'(64'h0F0F_F0F0_1234_ABCD));

      // R3, R4, R5: masked lanes at 32-bit width
      kwrite(3'd1, 64'h0000_0000_0000_A5C3);
      kwrite(3'd2, 64'h0000_0000_0000_0000);
      do_op("R3 R4 zeroing k1", a, b, c, d, 8'hE8, 2'd2, 3'd1, 1'b1, 1'b0, 3'd0, '0);
      do_op("R3 R5 merging k1", a, b, c, d, 8'hE8, 2'd2, 3'd1, 1'b0, 1'b0, 3'd0, '0);
      do_op("R5 all disabled merge", a, b, c, d, 8'h96, 2'd0, 3'd2, 1'b0, 1'b0, 3'd0, '0);
      check("R5 equals dst_old", last_exp, d);
      do_op("R4 all disabled zero", a, b, c, d, 8'h96, 2'd0, 3'd2, 1'b1, 1'b0, 3'd0, '0);
      check("R4 equals zero", last_exp, '0);

      // R6: each lane width with the same mask register
      kwrite(3'd3, 64'h9C3A_55E1_7B20_C48F);
      for (int e = 0; e < 4; e++)
         do_op($sformatf("R6 width code %0d", e), a, b, c, d, 8'h78, 2'(e), 3'd3, 1'b0, 1'b0, 3'd0, '0);

      // R7: upper mask bits ignored at 64-bit width
      kwrite(3'd4, 64'hFFFF_FFFF_FFFF_FF5A);
      do_op("R7 upper set", a, b, c, d, 8'h6C, 2'd3, 3'd4, 1'b1, 1'b0, 3'd0, '0);
      begin
         logic [VW-1:0] ref_hi;
         ref_hi = last_exp;
         kwrite(3'd4, 64'h0000_0000_0000_005A);
         do_op("R7 upper clear", a, b, c, d, 8'h6C, 2'd3, 3'd4, 1'b1, 1'b0, 3'd0, '0);
         check("R7 same result", last_exp, ref_hi);
      end

      // R9: out_valid drops and result holds
      do_op("R9 op", a, b, c, d, 8'h5A, 2'd1, 3'd6, 1'b0, 1'b0, 3'd0, '0);
      @(negedge clk);
      check("R9 out_valid low", VW'(out_valid), '0);
      check("R9 result held", result, last_exp);

      // R11: write to selected register in the same cycle as the op
      kwrite(3'd5, 64'h0000_0000_0000_00FF);
      do_op("R11 old mask used", a, b, c, d, 8'hE8, 2'd3, 3'd5, 1'b1, 1'b1, 3'd5, 64'h0000_0000_0000_0001);
      do_op("R11 new mask next", a, b, c, d, 8'hE8, 2'd3, 3'd5, 1'b1, 1'b0, 3'd0, '0);

      repeat (3) @(negedge clk);
      n_checks++;
      if (sb.size() != 0) begin
         n_fail++;
         $display("FAIL R9 actual=%0d pending expected=0 pending", sb.size());
      end
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule